// File: doc/BRIEF.md
# NVM Checksum Check and Refresh Engine

This block computes a 16-bit additive checksum over the lowest region of a word-addressed non-volatile memory. It runs one of two operations per start. In check mode it reads every word from address zero up to and including the checksum word. It reports a pass when the wrapped sum equals the fixed signature 0xBABA. In refresh mode it reads only the words below the checksum word, then writes the one value that brings the total to the signature.

The engine sits between a controller and a memory access path that is not part of this block. It issues one word read at a time on a request/acknowledge port and one word write on a second port of the same kind. Each accepted start ends with exactly one `done_o` pulse. The `pass_o` and `err_o` flags describe the result and stay valid until the next start.

Top module: `nvm_csum_engine`

## Requirements
- R1: The running sum is a plain 16-bit addition that wraps modulo 2^16; carries out of bit 15 are dropped.
- R2: In check mode (`mode_i` = 0) the engine reads addresses 0, 1, … `CSUM_ADDR` in ascending order, one at a time. It holds `rd_req_o` and `rd_addr_o` steady until the cycle in which `rd_ack_i` is high.
- R3: A check that completes without a read error ends with `pass_o` = 1 exactly when the wrapped sum of all those words is 0xBABA; `err_o` is 0 in both cases.
- R4: In refresh mode (`mode_i` = 1) the engine reads addresses 0 … `CSUM_ADDR`-1 in ascending order. It then issues a single write to address `CSUM_ADDR` whose data is 0xBABA minus the wrapped sum of those words.
- R5: A read acknowledged with `rd_err_i` = 1 aborts the operation at once, with no further read and no write. The next cycle carries `done_o` together with `err_o` = 1 and `pass_o` = 0.
- R6: In refresh mode a write acknowledged with `wr_err_i` = 1 ends with `err_o` = 1 and `pass_o` = 0. A clean write ends with `pass_o` = 1 and `err_o` = 0.
- R7: Every start accepted while idle produces exactly one single-cycle `done_o` pulse; `start_i` raised while an operation is running is ignored.
- R8: After reset all outputs are 0; `pass_o` and `err_o` keep their final values after `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (accepted only while idle) |
| mode_i | input | 1 | 0 = check, 1 = refresh; sampled with start |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result: checksum good / write succeeded |
| err_o | output | 1 | Result: read or write error |
| rd_req_o | output | 1 | Word read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Word read address |
| rd_ack_i | input | 1 | Read acknowledge, data and error valid with it |
| rd_data_i | input | DATA_W | Read data |
| rd_err_i | input | 1 | Read failed (valid with rd_ack_i) |
| wr_req_o | output | 1 | Word write request, held until acknowledged |
| wr_addr_o | output | ADDR_W | Word write address |
| wr_data_o | output | DATA_W | Word write data |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write failed (valid with wr_ack_i) |

## Verification
The properties assume that the memory side raises `rd_ack_i` only while `rd_req_o` is high, and `wr_ack_i` only while `wr_req_o` is high. They also assume the error inputs matter only in an acknowledge cycle. The stimulus keeps to these rules with a responder that acknowledges only a visible request, after a chosen latency of zero or more cycles. The responder then drops the acknowledge for at least one cycle and injects errors solely alongside an acknowledge. The one deliberate excursion is a start raised during a running operation, which the requirements define as ignored.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } csum_state_e;

   typedef enum logic {
      OP_CHECK   = 1'b0,
      OP_REFRESH = 1'b1
   } csum_op_e;

endpackage

// File: rtl/nvm_csum_accum.sv
module nvm_csum_accum #(
   parameter int unsigned            DATA_W    = 16,
   parameter logic [DATA_W-1:0]      SIGNATURE = 16'hBABA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              add_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              match_o,
   output logic [DATA_W-1:0] comp_o
);

   logic [DATA_W-1:0] sum_q;
   logic [DATA_W-1:0] sum_nx;

   // wrapping adder: the carry is simply not kept
   assign sum_nx  = sum_q + data_i;
   assign match_o = (sum_nx == SIGNATURE);
   assign comp_o  = SIGNATURE - sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (clr_i) begin
         sum_q <= '0;
      end else if (add_i) begin
         sum_q <= sum_nx;
      end
   end

endmodule

// File: rtl/nvm_csum_addr_gen.sv
module nvm_csum_addr_gen #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CSUM_ADDR = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   input  logic              upd_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);

   localparam logic [ADDR_W-1:0] LAST_CHECK = ADDR_W'(CSUM_ADDR);

   logic [ADDR_W-1:0] cnt_q;
   logic              last_chk;
   logic              last_upd;

   assign last_chk = (cnt_q == LAST_CHECK);

   generate
      if (CSUM_ADDR == 0) begin : g_no_upd_reads
         // refresh never reads in this variant
         assign last_upd = 1'b1;
      end else begin : g_upd_reads
         localparam logic [ADDR_W-1:0] LAST_UPD = ADDR_W'(CSUM_ADDR - 1);
         assign last_upd = (cnt_q == LAST_UPD);
      end
   endgenerate

   assign last_o = upd_i ? last_upd : last_chk;
   assign addr_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/nvm_csum_fsm.sv
module nvm_csum_fsm
   import nvm_csum_pkg::*;
#(
   parameter bit SKIP_UPD_READ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic mode_i,
   input  logic rd_ack_i,
   input  logic rd_err_i,
   input  logic wr_ack_i,
   input  logic wr_err_i,
   input  logic last_i,
   input  logic match_i,
   output logic upd_o,
   output logic rd_req_o,
   output logic wr_req_o,
   output logic done_o,
   output logic pass_o,
   output logic err_o,
   output logic clr_o,
   output logic add_o,
   output logic inc_o
);

   csum_state_e state_q;
   csum_op_e    op_q;
   logic        pass_q;
   logic        err_q;
   logic        good_rd;

   assign good_rd  = (state_q == ST_READ) && rd_ack_i && !rd_err_i;
   assign clr_o    = (state_q == ST_IDLE) && start_i;
   assign add_o    = good_rd;
   assign inc_o    = good_rd && !last_i;
   assign rd_req_o = (state_q == ST_READ);
   assign wr_req_o = (state_q == ST_WRITE);
   assign done_o   = (state_q == ST_DONE);
   assign pass_o   = pass_q;
   assign err_o    = err_q;
   assign upd_o    = (op_q == OP_REFRESH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_CHECK;
         pass_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  op_q   <= csum_op_e'(mode_i);
                  pass_q <= 1'b0;
                  err_q  <= 1'b0;
                  if (mode_i && SKIP_UPD_READ) state_q <= ST_WRITE;
                  else                         state_q <= ST_READ;
               end
            end
            ST_READ: begin
               if (rd_ack_i) begin
                  if (rd_err_i) begin
                     err_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end else if (last_i) begin
                     if (op_q == OP_REFRESH) begin
                        state_q <= ST_WRITE;
                     end else begin
                        pass_q  <= match_i;
                        state_q <= ST_DONE;
                     end
                  end
               end
            end
            ST_WRITE: begin
               if (wr_ack_i) begin
                  err_q   <= wr_err_i;
                  pass_q  <= !wr_err_i;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine #(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       CSUM_ADDR = 63,
   parameter logic [DATA_W-1:0] SIGNATURE = 16'hBABA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   output logic              done_o,
   output logic              pass_o,
   output logic              err_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_err_i,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_ack_i,
   input  logic              wr_err_i
);

   localparam bit SKIP_UPD_READ = (CSUM_ADDR == 0);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("nvm_csum_engine: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("nvm_csum_engine: DATA_W must be positive");
      end
      if (ADDR_W < 32 && CSUM_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_csum
         $error("nvm_csum_engine: CSUM_ADDR does not fit ADDR_W");
      end
   endgenerate

   logic clr;
   logic add;
   logic inc;
   logic upd;
   logic last;
   logic match;

   nvm_csum_fsm #(
      .SKIP_UPD_READ (SKIP_UPD_READ)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mode_i   (mode_i),
      .rd_ack_i (rd_ack_i),
      .rd_err_i (rd_err_i),
      .wr_ack_i (wr_ack_i),
      .wr_err_i (wr_err_i),
      .last_i   (last),
      .match_i  (match),
      .upd_o    (upd),
      .rd_req_o (rd_req_o),
      .wr_req_o (wr_req_o),
      .done_o   (done_o),
      .pass_o   (pass_o),
      .err_o    (err_o),
      .clr_o    (clr),
      .add_o    (add),
      .inc_o    (inc)
   );

   nvm_csum_addr_gen #(
      .ADDR_W    (ADDR_W),
      .CSUM_ADDR (CSUM_ADDR)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .inc_i  (inc),
      .upd_i  (upd),
      .addr_o (rd_addr_o),
      .last_o (last)
   );

   nvm_csum_accum #(
      .DATA_W    (DATA_W),
      .SIGNATURE (SIGNATURE)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .add_i   (add),
      .data_i  (rd_data_i),
      .match_o (match),
      .comp_o  (wr_data_o)
   );

   assign wr_addr_o = ADDR_W'(CSUM_ADDR);

endmodule

// File: rtl/nvm_csum_chk.sv
module nvm_csum_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CSUM_ADDR = 63
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic              pass_o,
   input logic              err_o,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_ack_i,
   input logic              rd_err_i,
   input logic              wr_req_o,
   input logic [ADDR_W-1:0] wr_addr_o
);

   a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_o && wr_req_o));

   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

   a_r2_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_addr_o <= ADDR_W'(CSUM_ADDR)));

   a_r4_wr_target: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> (wr_addr_o == ADDR_W'(CSUM_ADDR)));

   a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_ack_i && rd_err_i) |=> (done_o && err_o && !pass_o && !rd_req_o && !wr_req_o));

   a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !(pass_o && err_o));

   a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req_o && !wr_req_o && !done_o && $past(!rd_req_o && !wr_req_o))
      |-> ($stable(pass_o) || $past(done_o) || !$past(rst_n)) || (!pass_o && !err_o));

endmodule

bind nvm_csum_engine nvm_csum_chk #(
   .ADDR_W    (ADDR_W),
   .CSUM_ADDR (CSUM_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done_o    (done_o),
   .pass_o    (pass_o),
   .err_o     (err_o),
   .rd_req_o  (rd_req_o),
   .rd_addr_o (rd_addr_o),
   .rd_ack_i  (rd_ack_i),
   .rd_err_i  (rd_err_i),
   .wr_req_o  (wr_req_o),
   .wr_addr_o (wr_addr_o)
);

// File: tb/test_nvm_csum_engine.sv
module test_nvm_csum_engine;

   localparam int          AW  = 8;
   localparam int          DW  = 16;
   localparam int          C   = 63;
   localparam logic [15:0] SIG = 16'hBABA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic          done_o, pass_o, err_o;
   logic          rd_req_o, wr_req_o;
   logic [AW-1:0] rd_addr_o, wr_addr_o;
   logic [DW-1:0] wr_data_o;
   logic          rd_ack_i = 1'b0;
   logic [DW-1:0] rd_data_i = '0;
   logic          rd_err_i = 1'b0;
   logic          wr_ack_i = 1'b0;
   logic          wr_err_i = 1'b0;

   always #2 clk = ~clk;

   nvm_csum_engine #(.ADDR_W(AW), .DATA_W(DW), .CSUM_ADDR(C), .SIGNATURE(SIG)) i_nvm_csum_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .done_o(done_o), .pass_o(pass_o), .err_o(err_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
      .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i));

   logic [15:0] mem [0:C];
   int n_chk = 0;
   int n_fail = 0;
   int total_cyc = 0;

   // per-operation reference state
   int          exp_next, lat, wait_n, err_at, n_reads, n_writes, n_done;
   bit          wr_inj, reads_over, exp_write;
   logic [15:0] exp_wdata;
   logic        got_pass, got_err;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one clock of reference comparison plus memory responder
   task automatic step();
      @(negedge clk);
      total_cyc++;
      if (done_o) begin
         n_done++;
         got_pass = pass_o;
         got_err  = err_o;
      end
      if (rd_req_o && reads_over)
         check(1'b0, "R5 read issued after last/aborted read", {24'd0, rd_addr_o}, 32'hFFFF);
      if (wr_req_o && !exp_write && !wr_ack_i)
         check(1'b0, "R5 unexpected write", {24'd0, wr_addr_o}, 32'hFFFF);
      if (rd_ack_i) begin
         rd_ack_i = 1'b0;
         rd_err_i = 1'b0;
      end else if (rd_req_o && !reads_over) begin
         if (wait_n >= lat) begin
            check(rd_addr_o == AW'(exp_next), "R2/R4 read address order", {24'd0, rd_addr_o}, exp_next);
            rd_ack_i  = 1'b1;
            rd_data_i = mem[rd_addr_o[5:0]];
            rd_err_i  = (int'(rd_addr_o) == err_at);
            n_reads++;
            if (rd_err_i) reads_over = 1'b1;
            exp_next++;
            wait_n = 0;
         end else begin
            wait_n++;
         end
      end
      if (wr_ack_i) begin
         wr_ack_i = 1'b0;
         wr_err_i = 1'b0;
      end else if (wr_req_o && exp_write) begin
         if (wait_n >= lat) begin
            check(wr_addr_o == AW'(C), "R4 write address", {24'd0, wr_addr_o}, C);
            check(wr_data_o == exp_wdata, "R4 R1 write data", {16'd0, wr_data_o}, {16'd0, exp_wdata});
            wr_ack_i = 1'b1;
            wr_err_i = wr_inj;
            if (!wr_inj) mem[C] = wr_data_o;
            n_writes++;
            wait_n = 0;
         end else begin
            wait_n++;
         end
      end
   endtask

   task automatic run_op(input bit mode, input int latency, input int err_addr, input bit winj, input bit poke_busy);
      int          last_a, stop_a, n_exp_reads, steps;
      bit          rderr, e_pass, e_err;
      logic [15:0] sum;
      last_a = mode ? C - 1 : C;
      rderr  = (err_addr >= 0) && (err_addr <= last_a);
      stop_a = rderr ? err_addr : last_a;
      sum = '0;
      for (int i = 0; i <= last_a; i++) if (i < stop_a || (!rderr && i == stop_a)) sum = sum + mem[i];
      n_exp_reads = stop_a + 1;
      exp_write = mode && !rderr;
      exp_wdata = SIG - sum;
      e_err  = rderr || (mode && winj);
      e_pass = !e_err && (mode ? 1'b1 : (sum == SIG));
      lat = latency; err_at = err_addr; wr_inj = winj;
      exp_next = 0; wait_n = 0; n_reads = 0; n_writes = 0; n_done = 0;
      reads_over = 1'b0; got_pass = 1'b0; got_err = 1'b0;
      start_i = 1'b1;
      mode_i  = mode;
      step();
      start_i = 1'b0;
      steps = 0;
      while (n_done == 0 && steps < 5000) begin
         if (exp_next == n_exp_reads) reads_over = 1'b1;
         if (poke_busy && steps == 3) begin
            start_i = 1'b1;
            mode_i  = ~mode;
         end else begin
            start_i = 1'b0;
         end
         step();
         steps++;
      end
      start_i = 1'b0;
      if (n_done == 0) check(1'b0, "R7 watchdog: no done", 32'd0, 32'd1);
      reads_over = 1'b1;
      for (int k = 0; k < 4; k++) step();
      check(n_done == 1, "R7 one done per start", n_done, 1);
      check(n_reads == n_exp_reads, "R2/R4/R5 read count", n_reads, n_exp_reads);
      check(n_writes == (exp_write ? 1 : 0), "R4/R5 write count", n_writes, exp_write);
      check(got_pass == e_pass, "R3/R6 pass", got_pass, e_pass);
      check(got_err == e_err, "R5/R6 err", got_err, e_err);
      check(pass_o == e_pass && err_o == e_err, "R8 result held after done", {pass_o, err_o}, {e_pass, e_err});
   endtask

   task automatic fill(input logic [15:0] seed);
      for (int i = 0; i <= C; i++) mem[i] = (16'(i) * 16'h1357) ^ seed;
   endtask

   task automatic fix_sum();
      logic [15:0] s;
      s = '0;
      for (int i = 0; i < C; i++) s = s + mem[i];
      mem[C] = SIG - s;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!done_o && !pass_o && !err_o && !rd_req_o && !wr_req_o, "R8 reset outputs",
            {27'd0, done_o, pass_o, err_o, rd_req_o, wr_req_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done_o && !rd_req_o && !wr_req_o, "R8 idle after reset", {29'd0, done_o, rd_req_o, wr_req_o}, 32'd0);

      fill(16'h0F0F); fix_sum();
      run_op(1'b0, 0, -1, 1'b0, 1'b0);         // R3 good image
      mem[5] = mem[5] + 16'd1;
      run_op(1'b0, 2, -1, 1'b0, 1'b0);         // R3 corrupted image
      run_op(1'b1, 1, -1, 1'b0, 1'b0);         // R4 refresh repairs
      run_op(1'b0, 0, -1, 1'b0, 1'b0);         // R3 now passes
      for (int i = 0; i <= C; i++) mem[i] = 16'hFFFF;
      run_op(1'b1, 0, -1, 1'b0, 1'b0);         // R1 wrapping refresh
      run_op(1'b0, 3, -1, 1'b0, 1'b0);         // R1 wrapping check
      fill(16'hA5C3);
      run_op(1'b0, 1, 17, 1'b0, 1'b0);         // R5 read error in check
      run_op(1'b1, 0, 0, 1'b0, 1'b0);          // R5 error on first read in refresh
      run_op(1'b1, 0, C - 1, 1'b0, 1'b0);      // R5 error on last refresh read
      run_op(1'b1, 2, -1, 1'b1, 1'b0);         // R6 write error
      run_op(1'b0, 1, -1, 1'b0, 1'b1);         // R7 start while busy
      run_op(1'b1, 0, -1, 1'b0, 1'b1);         // R7 start while busy, refresh
      run_op(1'b0, 0, -1, 1'b0, 1'b0);         // R3 after refresh
      if (total_cyc > 150000) check(1'b0, "R7 global watchdog", total_cyc, 150000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule